// File: doc/BRIEF.md
# Predicated Element Write Gate with Condition Test

This block sits beside the element loop of a vector execution unit. For every element presented to it, it decides three things: whether the computed result is written to the destination, whether zero is written in its place, and whether the element's 4-bit condition field is written. The decision combines the predicate bit for the element with a test of one selected bit of the element's condition field. The result values themselves are computed and stored elsewhere. Only the enables come from this block.

An element is presented with `in_valid` and its index. The predicate bit is looked up from a mask, or taken as one when no predicate is in use. One condition bit (lt, gt, eq or so) is picked, and its polarity can be inverted. The condition field of any active element is always written, so software can analyse afterwards which elements failed the test. The result is written only when the test passes. Zeroing turns a masked-out or failing element into a write of zero. A compare-only mode discards every result write and keeps only the condition writes. The three enables appear registered, one clock after the element is presented.

Top module: `pred_elem_gate`

## Requirements
- R1: With `pred_en`=1 and `pred_mask[elem_idx]`=0 the element is masked out: `cond_we`=0, and `res_we`=0 unless zeroing applies (R4).
- R2: An element that is not masked out gets `cond_we`=1, whatever the test outcome, `zero_en` or `rc1_mode`.
- R3: A real result write (`res_we`=1, `res_zero`=0) happens only for an unmasked element whose test passes with `rc1_mode`=0. `cond_field` bits are lt=bit 3, gt=bit 2, eq=bit 1, so=bit 0. `test_sel` 0 picks lt, 1 picks gt, 2 picks eq and 3 picks so. The test passes when the picked bit XOR `test_inv` is 1.
- R4: With `zero_en`=1 and `rc1_mode`=0, an element that is masked out or fails the test gets `res_we`=1 and `res_zero`=1.
- R5: With `rc1_mode`=1, `res_we`=0 and `res_zero`=0 for every element, including under zeroing.
- R6: With `pred_en`=0 the mask is ignored and every element counts as unmasked.
- R7: With `zero_en`=0, a masked-out or failing element gets `res_we`=0, so its destination is left unchanged.
- R8: All outputs are registered and valid one clock after `in_valid`. A cycle without `in_valid` produces all-zero outputs one clock later. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An element is presented this cycle |
| elem_idx | input | IDX_W | Index of the element within the vector |
| pred_mask | input | NUM_ELEM | Predicate mask, one bit per element |
| pred_en | input | 1 | 1 = use pred_mask, 0 = treat the mask as all ones |
| zero_en | input | 1 | Zeroing enable |
| cond_field | input | 4 | Condition field of the element {lt,gt,eq,so} |
| test_sel | input | 2 | Condition bit to test (0 lt, 1 gt, 2 eq, 3 so) |
| test_inv | input | 1 | Invert the tested bit |
| rc1_mode | input | 1 | Compare-only mode: results discarded |
| out_valid | output | 1 | Registered copy of in_valid |
| res_we | output | 1 | Write the element's destination |
| res_zero | output | 1 | The write carries zero instead of the result |
| cond_we | output | 1 | Write the element's condition field |

## Verification
Every cycle, the assertions check the invariants that link the outputs to the inputs one clock earlier. These are: no condition write for a masked element, and a condition write for any active element when the predicate is off. Compare-only mode never writes a result. A zero write always comes with a write enable, and an idle cycle drives everything low. Some behaviour can only be shown by the bench's vectors: which condition bit each select value picks, the effect of the polarity inversion, the index lookup into the mask, and the exact enable triple for each combination of masking, test outcome and zeroing.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  typedef enum logic [1:0] {
    SEL_LT = 2'd0,
    SEL_GT = 2'd1,
    SEL_EQ = 2'd2,
    SEL_SO = 2'd3
  } cbit_sel_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef struct packed {
    logic res_we;
    logic res_zero;
    logic cond_we;
  } gate_t;

  localparam int unsigned COND_W = $bits(cond_t);

endpackage

// File: rtl/pg_mask_pick.sv
module pg_mask_pick #(
  parameter int unsigned NUM_ELEM = 64,
  localparam int unsigned IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                use_mask_i,
  output logic                bit_o
);

  logic [NUM_ELEM-1:0] onehot;
  logic                picked;

  // one-hot decode of the index, then AND-OR reduce: keeps depth logarithmic
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_dec
    assign onehot[g] = (idx_i == IDX_W'(g));
  end

  assign picked = |(onehot & mask_i);

  always_comb begin
    bit_o = use_mask_i ? picked : 1'b1;
  end

endmodule

// File: rtl/pg_cond_test.sv
module pg_cond_test
  import pgate_pkg::*;
(
  input  cond_t     cond_i,
  input  cbit_sel_e sel_i,
  input  logic      inv_i,
  output logic      pass_o
);

  logic picked;

  always_comb begin
    unique case (sel_i)
      SEL_LT:  picked = cond_i.lt;
      SEL_GT:  picked = cond_i.gt;
      SEL_EQ:  picked = cond_i.eq;
      SEL_SO:  picked = cond_i.so;
      default: picked = 1'b0;
    endcase
    pass_o = picked ^ inv_i;
  end

endmodule

// File: rtl/pg_decide.sv
module pg_decide
  import pgate_pkg::*;
(
  input  logic  valid_i,
  input  logic  pbit_i,
  input  logic  pass_i,
  input  logic  zero_en_i,
  input  logic  rc1_i,
  output gate_t gate_o
);

  logic active;
  logic rejected;

  always_comb begin
    active   = valid_i & pbit_i;
    rejected = valid_i & (~pbit_i | ~pass_i);

    gate_o          = '0;
    gate_o.cond_we  = active;
    if (!rc1_i) begin
      if (active && pass_i) begin
        gate_o.res_we = 1'b1;
      end else if (rejected && zero_en_i) begin
        gate_o.res_we   = 1'b1;
        gate_o.res_zero = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pred_elem_gate.sv
module pred_elem_gate
  import pgate_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 64,
  localparam int unsigned IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [IDX_W-1:0]    elem_idx,
  input  logic [NUM_ELEM-1:0] pred_mask,
  input  logic                pred_en,
  input  logic                zero_en,
  input  logic [COND_W-1:0]   cond_field,
  input  logic [1:0]          test_sel,
  input  logic                test_inv,
  input  logic                rc1_mode,
  output logic                out_valid,
  output logic                res_we,
  output logic                res_zero,
  output logic                cond_we
);

  logic  pbit;
  logic  pass;
  gate_t gate_nxt;
  gate_t gate_q;
  logic  valid_nxt;
  logic  valid_q;

  pg_mask_pick #(.NUM_ELEM(NUM_ELEM)) u_pick (
    .mask_i     (pred_mask),
    .idx_i      (elem_idx),
    .use_mask_i (pred_en),
    .bit_o      (pbit)
  );

  pg_cond_test u_test (
    .cond_i (cond_t'(cond_field)),
    .sel_i  (cbit_sel_e'(test_sel)),
    .inv_i  (test_inv),
    .pass_o (pass)
  );

  pg_decide u_dec (
    .valid_i   (in_valid),
    .pbit_i    (pbit),
    .pass_i    (pass),
    .zero_en_i (zero_en),
    .rc1_i     (rc1_mode),
    .gate_o    (gate_nxt)
  );

  always_comb begin
    valid_nxt = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gate_q  <= '0;
    end else begin
      valid_q <= valid_nxt;
      gate_q  <= gate_nxt;
    end
  end

  assign out_valid = valid_q;
  assign res_we    = gate_q.res_we;
  assign res_zero  = gate_q.res_zero;
  assign cond_we   = gate_q.cond_we;

  AST_MASKED_NO_COND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred_en && !pred_mask[elem_idx] |=> !cond_we); // R1
  AST_NOPRED_COND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !pred_en |=> cond_we); // R6
  AST_RC1_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rc1_mode |=> !res_we && !res_zero); // R5
  AST_ZERO_HAS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    res_zero |-> res_we && out_valid); // R4
  AST_RESULT_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    res_we && !res_zero |-> cond_we); // R3
  AST_NOZERO_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !zero_en |=> !res_zero); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !res_we && !res_zero && !cond_we); // R8

endmodule

// File: tb/sim_pred_elem_gate.sv
module sim_pred_elem_gate;

  localparam int unsigned NE = 64;
  localparam int unsigned IW = 6;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [IW-1:0] elem_idx;
  logic [NE-1:0] pred_mask;
  logic          pred_en;
  logic          zero_en;
  logic [3:0]    cond_field;
  logic [1:0]    test_sel;
  logic          test_inv;
  logic          rc1_mode;
  logic          out_valid;
  logic          res_we;
  logic          res_zero;
  logic          cond_we;

  int errors = 0;
  int checks = 0;

  pred_elem_gate #(.NUM_ELEM(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_idx(elem_idx),
    .pred_mask(pred_mask), .pred_en(pred_en), .zero_en(zero_en),
    .cond_field(cond_field), .test_sel(test_sel), .test_inv(test_inv),
    .rc1_mode(rc1_mode), .out_valid(out_valid), .res_we(res_we),
    .res_zero(res_zero), .cond_we(cond_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // entry: idx(6) pbit pen zen cond(4) sel(2) inv rc1 | exp we, zero, cwe
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {6'd5,  1'b1, 1'b1, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0, 3'b101}, // eq passes
    {6'd5,  1'b1, 1'b1, 1'b0, 4'b0010, 2'd2, 1'b1, 1'b0, 3'b001}, // inverted fails
    {6'd5,  1'b1, 1'b1, 1'b1, 4'b0010, 2'd2, 1'b1, 1'b0, 3'b111}, // fail, zeroing
    {6'd5,  1'b0, 1'b1, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0, 3'b000}, // masked
    {6'd5,  1'b0, 1'b1, 1'b1, 4'b0010, 2'd2, 1'b0, 1'b0, 3'b110}, // masked, zeroing
    {6'd5,  1'b0, 1'b0, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0, 3'b101}, // no predicate
    {6'd63, 1'b1, 1'b1, 1'b0, 4'b1000, 2'd0, 1'b0, 1'b1, 3'b001}, // rc1 pass
    {6'd63, 1'b1, 1'b1, 1'b1, 4'b0000, 2'd0, 1'b0, 1'b1, 3'b001}, // rc1 fail zero
    {6'd63, 1'b0, 1'b1, 1'b1, 4'b0000, 2'd0, 1'b0, 1'b1, 3'b000}, // rc1 masked
    {6'd0,  1'b1, 1'b1, 1'b0, 4'b0100, 2'd1, 1'b0, 1'b0, 3'b101}, // gt
    {6'd0,  1'b1, 1'b1, 1'b0, 4'b0001, 2'd3, 1'b0, 1'b0, 3'b101}, // so
    {6'd0,  1'b1, 1'b1, 1'b0, 4'b1110, 2'd3, 1'b0, 1'b0, 3'b001}, // so clear
    {6'd0,  1'b1, 1'b1, 1'b0, 4'b0111, 2'd0, 1'b1, 1'b0, 3'b101}, // lt inverted
    {6'd31, 1'b1, 1'b1, 1'b0, 4'b1011, 2'd1, 1'b0, 1'b0, 3'b001}  // gt clear
  };

  function automatic string tag_of(logic pbit, logic pen, logic rc1,
                                   logic zen, logic [2:0] exp);
    if (rc1)                    return "R5";
    if (!pen)                   return "R6";
    if (!pbit)                  return zen ? "R4" : "R1";
    if (exp[2] && !exp[1])      return "R3";
    if (exp[1])                 return "R4";
    return "R7";
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drive(logic [IW-1:0] idx, logic pbit, logic pen, logic zen,
                       logic [3:0] cf, logic [1:0] sel, logic inv, logic rc1);
    @(negedge clk);
    in_valid   = 1'b1;
    elem_idx   = idx;
    pred_mask  = pbit ? (NE'(1) << idx) : ~(NE'(1) << idx);
    pred_en    = pen;
    zero_en    = zen;
    cond_field = cf;
    test_sel   = sel;
    test_inv   = inv;
    rc1_mode   = rc1;
  endtask

  initial begin
    for (int w = 0; w < 5000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; elem_idx = '0; pred_mask = '0;
    pred_en = 1'b0; zero_en = 1'b0; cond_field = '0; test_sel = '0;
    test_inv = 1'b0; rc1_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8", "out_valid in reset", out_valid, 1'b0);
    check("R8", "res_we in reset", res_we, 1'b0);
    check("R8", "cond_we in reset", cond_we, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      string t;
      v = VEC[i];
      drive(v[19:14], v[13], v[12], v[11], v[10:7], v[6:5], v[4], v[3]);
      t = tag_of(v[13], v[12], v[3], v[11], v[2:0]);
      @(posedge clk);
      #1;
      check("R8", "out_valid", out_valid, 1'b1);
      check(t, "res_we", res_we, v[2]);
      check(t, "res_zero", res_zero, v[1]);
      check((v[12] && !v[13]) ? "R1" : "R2", "cond_we", cond_we, v[0]);
    end

    // R8 idle cycle with inputs that would otherwise write
    idle();
    @(posedge clk);
    #1;
    check("R8", "idle out_valid", out_valid, 1'b0);
    check("R8", "idle res_we", res_we, 1'b0);
    check("R8", "idle cond_we", cond_we, 1'b0);

    // R6 mask all zero but predicate disabled
    drive(6'd17, 1'b1, 1'b0, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0);
    pred_mask = '0;
    @(posedge clk);
    #1;
    check("R6", "no-pred zero mask res_we", res_we, 1'b1);
    check("R6", "no-pred zero mask cond_we", cond_we, 1'b1);

    // R1 neighbour bit set, own bit clear
    drive(6'd17, 1'b1, 1'b1, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0);
    pred_mask = NE'(1) << 18;
    @(posedge clk);
    #1;
    check("R1", "neighbour bit cond_we", cond_we, 1'b0);
    check("R7", "neighbour bit res_we", res_we, 1'b0);

    // R8 reset mid-stream clears registered outputs
    drive(6'd3, 1'b1, 1'b1, 1'b0, 4'b0010, 2'd2, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R8", "async reset res_we", res_we, 1'b0);
    check("R8", "async reset cond_we", cond_we, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule